// File: doc/BRIEF.md
# Dual-Bit SPI Transmit Master

This block is a byte-at-a-time SPI master with the serial clock idling low, in SPI mode 0. A requester hands it one byte per handshake. Each byte comes with a flag that picks single-bit or dual-bit transmission, a target code, and a flag that marks the byte as the last of a command. In single-bit mode the byte leaves on the data-out line one bit per serial clock, and the line from the target is shifted in at the same time. In dual-bit mode a spare select pin is borrowed as a second data-out line. Two bits then move on each serial clock, so a byte takes half as many clocks.

The serial clock half-period is set at run time in system clock cycles. For every bit the data is set up while the clock is low and held through the high phase. Targets 0 and 1 share one select line and target 2 has its own. When a byte marked last completes, every select line is released for one half-period before another byte can be taken. When the byte completes, the received byte is presented together with a one-cycle completion pulse.

Top module: `dbspi_tx_master`

## Requirements
- R1: After reset: `sck`=0, `mosi`=0, `aux_n`=1, `sel_n`=2'b11, `busy`=0, `done`=0, `in_ready`=1 and `rx_byte`=8'h00.
- R2: In single-bit mode (`in_dual`=0) a byte takes 8 serial clocks and leaves MSB first on `mosi`, one bit per clock. `aux_n` stays 1 throughout.
- R3: In dual-bit mode (`in_dual`=1) a byte takes 4 serial clocks carrying bit pairs [7:6], [5:4], [3:2], [1:0] in that order. The higher bit of each pair is on `mosi` and the lower bit is on `aux_n`. Outside a dual-bit byte, `aux_n` is 1.
- R4: Each low phase and each high phase of `sck` lasts H system cycles. H is the `half_div` value latched at acceptance, and a value of 0 counts as 1. `mosi` and `aux_n` change only while `sck` is low.
- R5: Select mapping, active low. Target codes 0 and 1 drive `sel_n[0]` low. Target code 2 drives `sel_n[1]` low. Target code 3 drives no line low. At most one line is low at any time.
- R6: When a byte with `in_last`=1 completes, both select lines go high in the completion cycle and stay high for H cycles with `in_ready` low. When a byte with `in_last`=0 completes, the select line stays low and `in_ready` returns in the completion cycle.
- R7: In single-bit mode `miso` is sampled as `sck` rises, MSB first, and the byte appears on `rx_byte` in the cycle `done` is high. A dual-bit byte returns 8'h00.
- R8: `busy` is high from the cycle after acceptance until the final falling edge of `sck`. In the cycle of that falling edge, `done` pulses for one cycle, `busy` drops and `mosi` returns to 0.
- R9: `in_ready` is low while a byte is in progress, and `in_valid` has no effect then. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_div | input | DIV_W | Serial clock half-period in system cycles (0 counts as 1) |
| in_valid | input | 1 | Byte request valid |
| in_ready | output | 1 | Ready to accept a byte |
| in_byte | input | 8 | Byte to transmit |
| in_dual | input | 1 | Dual-bit transmit for this byte |
| in_target | input | 2 | Target code 0..3 |
| in_last | input | 1 | Byte ends the command |
| miso | input | 1 | Serial data from target |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Primary serial data out |
| aux_n | output | 1 | Spare select pin, second data bit in dual mode |
| sel_n | output | 2 | Select lines, active low |
| busy | output | 1 | Byte transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Received byte, valid with `done` |

## Verification
The bench builds the block with `DIV_W` = 4. This puts half-periods of 0, 1, 2 and 3 within easy reach: 0 exercises the rule that zero counts as one, and 1 gives the tightest phases, where the data and clock registers change on adjacent edges. Over a single-bit command, a dual-bit command, a two-byte command with the select held between bytes, and a byte sent to the unmapped target, the values on every output are predicted for every cycle. `in_valid` is also raised with unrelated data in the middle of a byte.

// File: rtl/dbspi_pkg.sv
package dbspi_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned TGT_W  = 2;
    localparam int unsigned SEL_W  = 2;
    localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

endpackage

// File: rtl/dbspi_phase_timer.sv
module dbspi_phase_timer #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] limit,
    output logic             expire
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    assign expire = run && (cnt_q == limit - DIV_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (restart || !run) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R4: a running phase never counts past its length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/dbspi_sel_map.sv
module dbspi_sel_map
    import dbspi_pkg::*;
(
    input  logic [TGT_W-1:0] target,
    output logic [SEL_W-1:0] pat_n
);

    // line 0 is shared by target codes 0 and 1, line 1 serves code 2
    for (genvar i = 0; i < SEL_W; i++) begin : g_line
        logic hit;
        always_comb begin
            if (i == 0) begin
                hit = (target == TGT_W'(0)) || (target == TGT_W'(1));
            end else begin
                hit = (target == TGT_W'(2));
            end
        end
        assign pat_n[i] = ~hit;
    end

endmodule

// File: rtl/dbspi_tx_master.sv
module dbspi_tx_master
    import dbspi_pkg::*;
#(
    parameter int unsigned DIV_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   half_div,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [BYTE_W-1:0]  in_byte,
    input  logic               in_dual,
    input  logic [TGT_W-1:0]   in_target,
    input  logic               in_last,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               aux_n,
    output logic [SEL_W-1:0]   sel_n,
    output logic               busy,
    output logic               done,
    output logic [BYTE_W-1:0]  rx_byte
);

    localparam logic [CNT_W-1:0] SINGLE_CLKS = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] DUAL_CLKS   = CNT_W'(BYTE_W / 2);

    typedef struct packed {
        phase_e             phase;
        logic               sck;
        logic               mosi;
        logic               aux_n;
        logic [SEL_W-1:0]   sel_n;
        logic               busy;
        logic               done;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
        logic               dual;
        logic               last;
        logic [CNT_W-1:0]   left;
        logic [DIV_W-1:0]   half;
    } regs_t;

    regs_t d, q;

    logic             tick;
    logic             restart;
    logic [SEL_W-1:0] sel_pat;

    dbspi_sel_map u_sel_map (
        .target (in_target),
        .pat_n  (sel_pat)
    );

    dbspi_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (q.phase != PH_IDLE),
        .restart (restart),
        .limit   (q.half),
        .expire  (tick)
    );

    assign restart = (d.phase != q.phase);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    d.phase = PH_LOW;
                    d.busy  = 1'b1;
                    d.tx    = in_byte;
                    d.dual  = in_dual;
                    d.last  = in_last;
                    d.half  = (half_div == '0) ? DIV_W'(1) : half_div;
                    d.sel_n = sel_pat;
                    d.left  = in_dual ? DUAL_CLKS : SINGLE_CLKS;
                    d.rx    = '0;
                    d.mosi  = in_byte[BYTE_W-1];
                    d.aux_n = in_dual ? in_byte[BYTE_W-2] : 1'b1;
                end
            end
            PH_LOW: begin
                if (tick) begin
                    d.phase = PH_HIGH;
                    d.sck   = 1'b1;
                    if (!q.dual) begin
                        d.rx = {q.rx[BYTE_W-2:0], miso};
                    end
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    d.sck  = 1'b0;
                    d.left = q.left - CNT_W'(1);
                    if (q.left == CNT_W'(1)) begin
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.mosi  = 1'b0;
                        d.aux_n = 1'b1;
                        if (q.last) begin
                            d.phase = PH_GAP;
                            d.sel_n = '1;
                        end else begin
                            d.phase = PH_IDLE;
                        end
                    end else begin
                        d.phase = PH_LOW;
                        d.tx    = q.dual ? (q.tx << 2) : (q.tx << 1);
                        d.mosi  = d.tx[BYTE_W-1];
                        d.aux_n = q.dual ? d.tx[BYTE_W-2] : 1'b1;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    d.phase = PH_IDLE;
                end
            end
            default: begin
                d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.aux_n <= 1'b1;
            q.sel_n <= '1;
            q.half  <= DIV_W'(1);
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.phase == PH_IDLE);
    assign sck      = q.sck;
    assign mosi     = q.mosi;
    assign aux_n    = q.aux_n;
    assign sel_n    = q.sel_n;
    assign busy     = q.busy;
    assign done     = q.done;
    assign rx_byte  = q.rx;

    // R4: data lines hold still across a high phase
    a_r4_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> ($stable(mosi) && $stable(aux_n)));

    // R8: completion pulse coincides with clock low and busy released
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !sck && !mosi));

    // R8: the serial clock only rises during a byte
    a_r8_sck_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy);

    // R5: never two select lines at once
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sel_n));

    // R3: spare pin released whenever no byte runs
    a_r3_aux_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> aux_n);

    // R9: no acceptance while a byte runs
    a_r9_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);

    // R6: a command-ending byte releases all selects as it completes
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !in_ready) |-> (sel_n == '1));

endmodule

// File: tb/dbspi_tx_master_tb.sv
module dbspi_tx_master_tb;

    localparam int unsigned DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] half_div = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_byte = '0;
    logic          in_dual = 1'b0;
    logic [1:0]    in_target = '0;
    logic          in_last = 1'b0;
    logic          miso;
    logic          sck, mosi, aux_n, busy, done;
    logic [1:0]    sel_n;
    logic [7:0]    rx_byte;

    always #5 clk = ~clk;

    dbspi_tx_master #(.DIV_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .in_dual(in_dual), .in_target(in_target), .in_last(in_last),
        .miso(miso), .sck(sck), .mosi(mosi), .aux_n(aux_n),
        .sel_n(sel_n), .busy(busy), .done(done), .rx_byte(rx_byte)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // target model: presents slv_byte MSB first, advancing on each falling clock
    logic [7:0] slv_byte = '0;
    int         slv_idx  = 0;
    int         slv_base = 0;
    always @(negedge sck) slv_idx = slv_idx + 1;
    always_comb begin
        int k;
        k = slv_idx - slv_base;
        miso = (k >= 0 && k < 8) ? slv_byte[7-k] : 1'b0;
    end

    typedef struct packed {
        logic       sck, mosi, aux_n;
        logic [1:0] sel_n;
        logic       busy, done, ready, dual;
        logic [7:0] rx;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    logic [1:0] idle_sel = 2'b11;

    function automatic exp_t idle_entry(logic [1:0] s);
        exp_t e;
        e = '0;
        e.aux_n = 1'b1;
        e.sel_n = s;
        e.ready = 1'b1;
        return e;
    endfunction

    function automatic logic [1:0] map_sel(logic [1:0] t);
        if (t == 2'd0 || t == 2'd1) return 2'b10;
        if (t == 2'd2) return 2'b01;
        return 2'b11;
    endfunction

    task automatic push_byte(logic [7:0] b, logic dl, logic [1:0] t,
                             logic lst, int h, logic [7:0] rxv);
        exp_t e;
        logic [1:0] s;
        int n;
        s = map_sel(t);
        n = dl ? 4 : 8;
        for (int c = 0; c < n; c++) begin
            e = '0;
            e.mosi  = dl ? b[7-2*c] : b[7-c];
            e.aux_n = dl ? b[6-2*c] : 1'b1;
            e.sel_n = s;
            e.busy  = 1'b1;
            e.dual  = dl;
            for (int i = 0; i < h; i++) exp_q.push_back(e);
            e.sck = 1'b1;
            for (int i = 0; i < h; i++) exp_q.push_back(e);
        end
        e = '0;
        e.aux_n = 1'b1;
        e.sel_n = lst ? 2'b11 : s;
        e.done  = 1'b1;
        e.ready = !lst;
        e.rx    = dl ? 8'h00 : rxv;
        exp_q.push_back(e);
        if (lst) begin
            e.done = 1'b0;
            e.ready = 1'b0;
            for (int i = 1; i < h; i++) exp_q.push_back(e);
        end
        idle_sel = lst ? 2'b11 : s;
    endtask

    // cycle model, driven only by bench inputs and its own state
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            idle_sel = 2'b11;
            cur = idle_entry(2'b11);
        end else begin
            if (in_valid && cur.ready) begin
                push_byte(in_byte, in_dual, in_target, in_last,
                          (half_div == 0) ? 1 : int'(half_div), slv_byte);
            end
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else cur = idle_entry(idle_sel);
        end
    end

    task automatic chk(string req, string what, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     req, what, act, expv, cycles);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "sck", {7'd0, sck}, {7'd0, cur.sck});
            chk(cur.dual ? "R3" : "R2", "mosi", {7'd0, mosi}, {7'd0, cur.mosi});
            chk("R3", "aux_n", {7'd0, aux_n}, {7'd0, cur.aux_n});
            chk("R5/R6", "sel_n", {6'd0, sel_n}, {6'd0, cur.sel_n});
            chk("R8", "busy", {7'd0, busy}, {7'd0, cur.busy});
            chk("R8", "done", {7'd0, done}, {7'd0, cur.done});
            chk("R9", "in_ready", {7'd0, in_ready}, {7'd0, cur.ready});
            if (cur.done) chk("R7", "rx_byte", rx_byte, cur.rx);
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    task automatic send(logic [7:0] b, logic dl, logic [1:0] t, logic lst,
                        logic [DW-1:0] h, logic [7:0] sb);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        slv_byte  = sb;
        slv_base  = slv_idx;
        half_div  = h;
        in_byte   = b;
        in_dual   = dl;
        in_target = t;
        in_last   = lst;
        in_valid  = 1'b1;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "sck", {7'd0, sck}, 8'd0);
        chk("R1", "mosi", {7'd0, mosi}, 8'd0);
        chk("R1", "aux_n", {7'd0, aux_n}, 8'd1);
        chk("R1", "sel_n", {6'd0, sel_n}, 8'd3);
        chk("R1", "busy/done", {6'd0, busy, done}, 8'd0);
        chk("R1", "in_ready", {7'd0, in_ready}, 8'd1);
        chk("R1", "rx_byte", rx_byte, 8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R7 R5: single-bit byte to target 0, fastest clock
        send(8'hA5, 1'b0, 2'd0, 1'b1, 4'd1, 8'h3C);
        // R3: dual-bit byte to target 2
        send(8'hB4, 1'b1, 2'd2, 1'b1, 4'd2, 8'hFF);
        // R6: two-byte command to target 1, select held between bytes
        send(8'h81, 1'b0, 2'd1, 1'b0, 4'd3, 8'hC3);
        send(8'h7E, 1'b0, 2'd1, 1'b1, 4'd3, 8'h5A);
        // R4 R5: zero half-period counts as one, unmapped target
        send(8'h6C, 1'b0, 2'd3, 1'b1, 4'd0, 8'h96);
        // R9: in_valid raised mid-byte with other data is ignored
        send(8'h1E, 1'b1, 2'd0, 1'b0, 4'd2, 8'h00);
        @(negedge clk);
        in_byte  = 8'hFF;
        in_dual  = 1'b0;
        in_last  = 1'b1;
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        send(8'hD2, 1'b1, 2'd0, 1'b1, 4'd1, 8'h00);
        // R3: dual then single in one command on target 2
        send(8'h4B, 1'b1, 2'd2, 1'b0, 4'd1, 8'h00);
        send(8'hE7, 1'b0, 2'd2, 1'b1, 4'd2, 8'h18);
        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule